// File: doc/BRIEF.md
# Pattern-Shift Fractional Clock Divider

This block turns a fast clock into a slower one by playing back a stored bit waveform, one bit per fast-clock cycle, and repeating it. The waveform is not made by a counter. It is a programmable word whose playback length is picked by a 2-bit select code. Because a word can hold several output periods of unequal length, the average division ratio can be fractional (3.5, 2.5, 3.75 and so on). A fixed internal 25-bit waveform gives a 6.25 ratio, and a bypass path gives divide-by-1. The output is a waveform that is sampled on the fast clock, so it can serve as a clock-enable or be handed to a clock-tree cell further on.

Software programs the divider as follows. It drops the enable and writes the length select. It raises the preset strobe while it writes the pattern, lowers preset, and then raises the enable. The block has four states:
- `ST_OFF`: output low, stored waveform held.
- `ST_LOAD`: output low, waveform and length reloaded every cycle.
- `ST_PASS`: output high every cycle, waveform held.
- `ST_SPIN`: output plays the waveform.

The next state is chosen from the inputs in priority order:
- preset high selects `ST_LOAD`.
- otherwise, enable low selects `ST_OFF`.
- otherwise, bypass high selects `ST_PASS`.
- otherwise the state is `ST_SPIN`.

Each transition takes effect at the clock edge that samples those inputs, so the output follows the inputs one cycle later.

Top module: `patshift_div`

## Requirements
- R1: While reset is asserted and in the cycles after release with enable and preset low, `div_o` is 0.
- R2: In every cycle after an edge that samples `preset_i` high, `div_o` is 0. During that time the waveform and length are reloaded at every edge, so the last value presented before preset falls is the one kept.
- R3: Length select 0 plays the low 12 bits of `pattern_i`, most significant first: bit 11 appears in the first running cycle after preset, then bits 10 down to 0, then it wraps (0x0DB6 gives divide-by-3).
- R4: Length select 1 plays the low 14 bits, from bit 13 down to bit 0, and wraps (0x36CC gives divide-by-3.5).
- R5: Length select 2 plays all 15 bits, from bit 14 down to bit 0, and wraps (0x5294 gives divide-by-2.5).
- R6: Length select 3 ignores `pattern_i` and plays the fixed 25-bit word 0x1C71C78 from bit 24 down to bit 0. That word holds four periods of 6, 6, 6 and 7 cycles, which averages divide-by-6.25.
- R7: With enable high, bypass high and preset low, `div_o` is 1 in the next cycle. The playback position does not move, and playback resumes from the next unplayed bit when bypass falls.
- R8: With enable low and preset low, `div_o` is 0 in the next cycle, whatever the value of bypass. The stored waveform and position are kept, and playback resumes from the next unplayed bit when enable returns.
- R9: Preset takes priority over enable and bypass. A preset sampled together with both enable and bypass high still gives 0. A preset sampled while enable is low still loads the waveform.
- R10: Changes to `len_sel_i` or `pattern_i` while preset is low have no effect on the waveform being played.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Output enable; low forces the output low |
| bypass_i | input | 1 | Divide-by-1: output held high while enabled |
| preset_i | input | 1 | Load strobe for pattern and length select |
| len_sel_i | input | 2 | Waveform length code: 0=12, 1=14, 2=15, 3=fixed 25-bit word |
| pattern_i | input | 15 | Waveform bits, played most significant first |
| div_o | output | 1 | Divided waveform, one bit per source cycle |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the preset strobe together with enable and bypass. A vector drives all three high at once, and the scoreboard expects a low output (preset wins). A later vector loads a pattern while enable is low, and playback must then start at the top bit of the new pattern.

The second pair is a playback step together with enable or bypass falling or rising. Enable and bypass are toggled in the middle of a run. The scoreboard keeps its own count of played bits, so any skipped or repeated bit at the resume point shows up as a miscompare against the expected next bit.

// File: rtl/patshift_pkg.sv
package patshift_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,   // output low, waveform held
        ST_LOAD = 2'd1,   // parallel load, output low
        ST_PASS = 2'd2,   // divide-by-1, output high
        ST_SPIN = 2'd3    // waveform playback
    } div_state_e;

    // Length select codes
    localparam logic [1:0] SEL_SHORT = 2'd0;
    localparam logic [1:0] SEL_MID   = 2'd1;
    localparam logic [1:0] SEL_LONG  = 2'd2;
    localparam logic [1:0] SEL_FIXED = 2'd3;

endpackage

// File: rtl/patshift_seed.sv
module patshift_seed
    import patshift_pkg::*;
#(
    parameter int PAT_W   = 15,
    parameter int RING_W  = 25,
    parameter int LEN_W   = 5,
    parameter int LEN0    = 12,
    parameter int LEN1    = 14,
    parameter int LEN2    = 15,
    parameter int FIX_LEN = 25,
    parameter logic [FIX_LEN-1:0] FIX_PAT = 25'h1C71C78
) (
    input  logic [1:0]        sel_i,
    input  logic [PAT_W-1:0]  pat_i,
    output logic [RING_W-1:0] seed_o,
    output logic [LEN_W-1:0]  len_o
);

    localparam logic [RING_W-1:0] FIX_EXT = RING_W'(FIX_PAT);

    logic use_fixed;

    always_comb begin
        unique case (sel_i)
            SEL_SHORT: len_o = LEN_W'(LEN0);
            SEL_MID:   len_o = LEN_W'(LEN1);
            SEL_LONG:  len_o = LEN_W'(LEN2);
            SEL_FIXED: len_o = LEN_W'(FIX_LEN);
        endcase
    end

    assign use_fixed = (sel_i == SEL_FIXED);

    // Per-bit seed: fixed word, or the pattern masked to the active length
    for (genvar i = 0; i < RING_W; i++) begin : g_seed
        if (i < PAT_W) begin : g_pat
            assign seed_o[i] = use_fixed ? FIX_EXT[i]
                                         : (pat_i[i] & (LEN_W'(i) < len_o));
        end else begin : g_fix
            assign seed_o[i] = use_fixed & FIX_EXT[i];
        end
    end

endmodule

// File: rtl/patshift_ring.sv
module patshift_ring #(
    parameter int RING_W = 25,
    parameter int LEN_W  = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              rot_i,
    input  logic [RING_W-1:0] seed_i,
    input  logic [LEN_W-1:0]  seed_len_i,
    output logic              head_o
);

    logic [RING_W-1:0] sr_q;
    logic [RING_W-1:0] sr_nxt;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  top_idx;

    assign top_idx = len_q - LEN_W'(1);
    assign head_o  = sr_q[top_idx];

    // Rotate left inside the active length; bits above it stay zero
    always_comb begin
        for (int i = 0; i < RING_W; i++) begin
            if (i == 0)
                sr_nxt[i] = head_o;
            else if (i < int'(len_q))
                sr_nxt[i] = sr_q[i-1];
            else
                sr_nxt[i] = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sr_q  <= '0;
            len_q <= LEN_W'(RING_W);
        end else if (load_i) begin
            sr_q  <= seed_i;
            len_q <= seed_len_i;
        end else if (rot_i) begin
            sr_q  <= sr_nxt;
        end
    end

    // R3: a playback step keeps the waveform content
    ones_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rot_i && !load_i) |=> ($countones(sr_q) == $past($countones(sr_q))));

    // R8: no step and no load leaves the waveform untouched
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rot_i && !load_i) |=> $stable(sr_q));

    // R10: the length changes only through a load
    len_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(len_q));

endmodule

// File: rtl/patshift_fsm.sv
module patshift_fsm
    import patshift_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic bypass_i,
    input  logic preset_i,
    input  logic head_i,
    output logic rot_o,
    output logic div_o
);

    div_state_e state_q;
    div_state_e state_d;

    // Next state: preset, then enable, then bypass
    always_comb begin
        if (preset_i)
            state_d = ST_LOAD;
        else if (!en_i)
            state_d = ST_OFF;
        else if (bypass_i)
            state_d = ST_PASS;
        else
            state_d = ST_SPIN;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // A cycle spent playing consumes its bit at the following edge
    assign rot_o = (state_q == ST_SPIN) && !preset_i;

    always_comb begin
        unique case (state_q)
            ST_OFF:  div_o = 1'b0;
            ST_LOAD: div_o = 1'b0;
            ST_PASS: div_o = 1'b1;
            ST_SPIN: div_o = head_i;
        endcase
    end

    // R2
    load_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        preset_i |=> !div_o);

    // R8
    off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!preset_i && !en_i) |=> !div_o);

    // R7
    pass_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!preset_i && en_i && bypass_i) |=> div_o);

    // R9
    preset_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (preset_i && en_i && bypass_i) |=> (!div_o && !rot_o));

endmodule

// File: rtl/patshift_div.sv
module patshift_div #(
    parameter int PAT_W   = 15,
    parameter int LEN0    = 12,
    parameter int LEN1    = 14,
    parameter int LEN2    = 15,
    parameter int FIX_LEN = 25,
    parameter logic [FIX_LEN-1:0] FIX_PAT = 25'h1C71C78
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             bypass_i,
    input  logic             preset_i,
    input  logic [1:0]       len_sel_i,
    input  logic [PAT_W-1:0] pattern_i,
    output logic             div_o
);

    localparam int RING_W = (FIX_LEN > PAT_W) ? FIX_LEN : PAT_W;
    localparam int LEN_W  = $clog2(RING_W + 1);

    logic [RING_W-1:0] seed;
    logic [LEN_W-1:0]  seed_len;
    logic              head;
    logic              rot;

    patshift_seed #(
        .PAT_W   (PAT_W),
        .RING_W  (RING_W),
        .LEN_W   (LEN_W),
        .LEN0    (LEN0),
        .LEN1    (LEN1),
        .LEN2    (LEN2),
        .FIX_LEN (FIX_LEN),
        .FIX_PAT (FIX_PAT)
    ) u_seed (
        .sel_i  (len_sel_i),
        .pat_i  (pattern_i),
        .seed_o (seed),
        .len_o  (seed_len)
    );

    patshift_ring #(
        .RING_W (RING_W),
        .LEN_W  (LEN_W)
    ) u_ring (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (preset_i),
        .rot_i      (rot),
        .seed_i     (seed),
        .seed_len_i (seed_len),
        .head_o     (head)
    );

    patshift_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en_i),
        .bypass_i (bypass_i),
        .preset_i (preset_i),
        .head_i   (head),
        .rot_o    (rot),
        .div_o    (div_o)
    );

    // R1: disabled without preset gives a low output
    reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !preset_i) |=> (div_o == 1'b0));

endmodule

// File: tb/patshift_div_test.sv
module patshift_div_test;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        en_i = 1'b0;
    logic        bypass_i = 1'b0;
    logic        preset_i = 1'b0;
    logic [1:0]  len_sel_i = 2'd0;
    logic [14:0] pattern_i = '0;
    logic        div_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic  exp_q[$];
    string tag_q[$];

    // Model of the waveform state, taken from the requirements
    logic [24:0] m_pat = '0;
    int          m_len = 25;
    int          m_cnt = 0;

    always #10 clk_i = ~clk_i;   // 50 MHz

    patshift_div uut (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .bypass_i  (bypass_i),
        .preset_i  (preset_i),
        .len_sel_i (len_sel_i),
        .pattern_i (pattern_i),
        .div_o     (div_o)
    );

    function automatic int len_of(input logic [1:0] s);
        case (s)
            2'd0: return 12;
            2'd1: return 14;
            2'd2: return 15;
            default: return 25;
        endcase
    endfunction

    // Driver: apply one cycle of inputs and push the expected output
    task automatic step(input logic en, input logic byp, input logic pre,
                        input logic [1:0] sel, input logic [14:0] pat,
                        input string tag);
        logic e;
        @(negedge clk_i);
        en_i = en; bypass_i = byp; preset_i = pre;
        len_sel_i = sel; pattern_i = pat;
        if (pre) begin
            m_pat = (sel == 2'd3) ? 25'h1C71C78 : (25'(pat) & ((25'd1 << len_of(sel)) - 25'd1));
            m_len = len_of(sel);
            m_cnt = 0;
            e = 1'b0;
        end else if (!en) begin
            e = 1'b0;
        end else if (byp) begin
            e = 1'b1;
        end else begin
            e = m_pat[m_len - 1 - (m_cnt % m_len)];
            m_cnt++;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic play(input int n, input logic [1:0] sel, input logic [14:0] pat,
                        input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, sel, pat, tag);
    endtask

    // Monitor: compare away from the active edge
    initial begin
        forever begin
            @(posedge clk_i);
            #4;
            if (exp_q.size() > 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                vectors++;
                if (div_o !== e) begin
                    miscompares++;
                    $display("FAIL %s: div_o got %0b expected %0b at %0t", t, div_o, e, $time);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: output low while reset is held
        repeat (3) @(negedge clk_i);
        vectors++;
        if (div_o !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: div_o got %0b expected 0", div_o);
        end
        rst_ni = 1'b1;
        step(1'b0, 1'b0, 1'b0, 2'd0, 15'h0, "R1");
        step(1'b0, 1'b0, 1'b0, 2'd0, 15'h0, "R1");

        // R2: preset over two cycles, last pattern wins
        step(1'b0, 1'b0, 1'b1, 2'd0, 15'h0000, "R2");
        step(1'b0, 1'b0, 1'b1, 2'd0, 15'h0DB6, "R2");
        play(24, 2'd0, 15'h0DB6, "R3");

        // R4: 14-bit waveform, divide-by-3.5
        step(1'b0, 1'b0, 1'b0, 2'd0, 15'h0, "R4");
        step(1'b0, 1'b0, 1'b1, 2'd1, 15'h36CC, "R4");
        play(28, 2'd1, 15'h36CC, "R4");

        // R5: 15-bit waveform, divide-by-2.5
        step(1'b0, 1'b0, 1'b1, 2'd2, 15'h5294, "R5");
        play(30, 2'd2, 15'h5294, "R5");

        // R6: fixed word, pattern input ignored
        step(1'b0, 1'b0, 1'b1, 2'd3, 15'h7FFF, "R6");
        play(50, 2'd3, 15'h7FFF, "R6");

        // R8: enable drops mid-run, bypass ignored while disabled
        step(1'b0, 1'b0, 1'b1, 2'd0, 15'h0E38, "R8");
        play(5, 2'd0, 15'h0E38, "R8");
        step(1'b0, 1'b0, 1'b0, 2'd0, 15'h0E38, "R8");
        step(1'b0, 1'b1, 1'b0, 2'd0, 15'h0E38, "R8");
        step(1'b0, 1'b1, 1'b0, 2'd0, 15'h0E38, "R8");
        step(1'b0, 1'b0, 1'b0, 2'd0, 15'h0E38, "R8");
        play(10, 2'd0, 15'h0E38, "R8");

        // R7: bypass mid-run
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 2'd0, 15'h0E38, "R7");
        play(8, 2'd0, 15'h0E38, "R7");

        // R10: select and pattern change without preset
        play(14, 2'd2, 15'h7FFF, "R10");

        // R9: preset beats enable and bypass; load while disabled
        step(1'b1, 1'b1, 1'b1, 2'd1, 15'h3C78, "R9");
        step(1'b0, 1'b0, 1'b1, 2'd1, 15'h3C78, "R9");
        step(1'b0, 1'b0, 1'b0, 2'd1, 15'h3C78, "R9");
        play(21, 2'd1, 15'h3C78, "R9");

        // R3: divide-by-12 on the short length
        step(1'b0, 1'b0, 1'b1, 2'd0, 15'h0FC0, "R3");
        play(26, 2'd0, 15'h0FC0, "R3");

        step(1'b0, 1'b0, 1'b0, 2'd0, 15'h0, "R8");
        repeat (3) @(negedge clk_i);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule